// File: doc/BRIEF.md
# Three-Wire Latched Configuration Register

This block is a serial configuration port with three inputs: a serial clock, a serial data line and a latch-enable line. Each rising serial clock edge shifts one bit into a 24-bit shift register. The most significant bit is sent first. When the latch-enable line rises, the word in the shift register is committed to one of four parallel holding words. The two least significant bits of the word choose which one. The other 22 bits become that holding word's contents.

The four holding words are the reference-divider word, the A/B-divider word, the function word and the initialization word. A write to the initialization word also writes the same payload into the function word. It also raises a one-cycle counter-reset strobe for the downstream dividers. The shift register lives in the serial clock domain. A two-flop synchronizer carries the latch-enable line into the system clock domain. There a small transfer state machine turns each rising latch-enable edge into exactly one commit cycle. The MSB of the shift register drives a serial output, so devices can be daisy-chained or shifted data read back.

The transfer state machine has three states:
- ST_IDLE waits for the synchronized latch-enable to be high.
- ST_COMMIT lasts one system cycle. In it the addressed holding word is written and the load strobe is raised.
- ST_HOLD waits for the synchronized latch-enable to fall.

Its transitions are:
- ST_IDLE to ST_COMMIT when latch-enable is seen high.
- ST_COMMIT to ST_HOLD, always.
- ST_HOLD to ST_IDLE when latch-enable is seen low.

Top module: `cfg3w_top`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into bit 0 of a 24-bit shift register. Words are sent MSB first. When more than 24 bits are sent before a transfer, only the last 24 are kept.
- R2: `ser_out` always equals bit 23 of the shift register. After 24 bits have been shifted in, it equals the first bit sent.
- R3: On a rising edge of `ser_le` (after two-flop synchronization into `sys_clk`), the shift register bits 23:2 are copied into the holding word chosen by bits 1:0. The codes are 00 reference word, 01 A/B word, 10 function word and 11 initialization word. The new value is visible within 5 `sys_clk` cycles of the rise.
- R4: Holding words not addressed by a transfer keep their contents. Shifting bits without a latch-enable rise changes no holding word.
- R5: A transfer with address 11 writes the same 22-bit payload into both the initialization word and the function word. During that commit cycle it raises `ctr_rst_stb` for exactly one `sys_clk` cycle. Other addresses never raise it.
- R6: `load_stb` is high for exactly one `sys_clk` cycle per rising edge of `ser_le`, however long `ser_le` stays high.
- R7: While `rst_n` is low, the shift register and all four holding words are cleared asynchronously. `ser_out`, `load_stb` and `ctr_rst_stb` are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the holding words and transfer control |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; rising edge commits the shifted word |
| ser_out | output | 1 | MSB of the shift register, for chaining or read-back |
| ref_word | output | 22 | Reference-divider holding word |
| ab_word | output | 22 | A/B-divider holding word |
| func_word | output | 22 | Function holding word |
| init_word | output | 22 | Initialization holding word |
| load_stb | output | 1 | One-cycle pulse when a transfer commits |
| ctr_rst_stb | output | 1 | One-cycle counter-reset pulse on initialization writes |

## Verification
Four properties are checked on every system cycle:
- `load_stb` never lasts more than one cycle.
- A commit only happens while the synchronized latch-enable is high.
- Holding words stay unchanged in any cycle without a write.
- The cycle after a counter-reset strobe, the function word equals the initialization word.

Other behaviours can only be shown by the bench's scenarios, because they depend on the serial stream as a whole:
- MSB-first ordering.
- Keeping only the last 24 bits.
- Correct decoding of all four addresses against a model.
- A single commit for a latch-enable held high for many cycles.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    // Destination code carried in the two low bits of every serial word
    typedef enum logic [1:0] {
        TGT_REF  = 2'b00,
        TGT_AB   = 2'b01,
        TGT_FUNC = 2'b10,
        TGT_INIT = 2'b11
    } tgt_e;

    // Transfer control states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_COMMIT = 2'b01,
        ST_HOLD   = 2'b10
    } xfer_st_e;

    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned N_TGT   = 4;

endpackage

// File: rtl/cfg3w_shift.sv
module cfg3w_shift #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              ser_clk,
    input  logic              rst_n,
    input  logic              din,
    output logic [WORD_W-1:0] word_q,
    output logic              msb_o
);

    logic [WORD_W-1:0] sr_q;

    // R1: MSB-first shift, new bit enters at bit 0
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[WORD_W-2:0], din};
        end
    end

    assign word_q = sr_q;
    assign msb_o  = sr_q[WORD_W-1];   // R2

endmodule

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfg3w_xfer_fsm.sv
module cfg3w_xfer_fsm
    import cfg3w_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_sync,
    input  tgt_e addr,
    output logic wr_en,
    output logic load_stb,
    output logic ctr_rst_stb
);

    xfer_st_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (le_sync) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_HOLD;
            ST_HOLD:   if (!le_sync) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_en       = 1'b0;
        load_stb    = 1'b0;
        ctr_rst_stb = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_COMMIT: begin
                wr_en       = 1'b1;
                load_stb    = 1'b1;
                ctr_rst_stb = (addr == TGT_INIT);
            end
            ST_HOLD: ;
            default: ;
        endcase
    end

    // R6: one load pulse per latch-enable rise
    assert_single_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    // R3: a commit only while the synchronized latch-enable is high
    assert_load_needs_le_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> le_sync);

endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank
    import cfg3w_pkg::*;
#(
    parameter int unsigned PAY_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  tgt_e             sel,
    input  logic [PAY_W-1:0] wdata,
    output logic [PAY_W-1:0] ref_q,
    output logic [PAY_W-1:0] ab_q,
    output logic [PAY_W-1:0] func_q,
    output logic [PAY_W-1:0] init_q
);

    logic [PAY_W-1:0] hold_q [N_TGT];

    generate
        for (genvar g = 0; g < N_TGT; g++) begin : g_hold
            logic hit;
            // R5: the function word also accepts initialization writes
            if (g == int'(TGT_FUNC)) begin : g_func
                assign hit = wr_en && ((sel == TGT_FUNC) || (sel == TGT_INIT));
            end else begin : g_plain
                assign hit = wr_en && (sel == tgt_e'(g));
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   hold_q[g] <= '0;
                else if (hit) hold_q[g] <= wdata;
            end
        end
    endgenerate

    assign ref_q  = hold_q[int'(TGT_REF)];
    assign ab_q   = hold_q[int'(TGT_AB)];
    assign func_q = hold_q[int'(TGT_FUNC)];
    assign init_q = hold_q[int'(TGT_INIT)];

    // R4: nothing moves without a write
    assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ref_q) && $stable(ab_q) && $stable(func_q) && $stable(init_q)));

endmodule

// File: rtl/cfg3w_top.sv
module cfg3w_top
    import cfg3w_pkg::*;
#(
    parameter int unsigned WORD_W      = 24,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PAY_W      = WORD_W - ADDR_W
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    output logic             ser_out,
    output logic [PAY_W-1:0] ref_word,
    output logic [PAY_W-1:0] ab_word,
    output logic [PAY_W-1:0] func_word,
    output logic [PAY_W-1:0] init_word,
    output logic             load_stb,
    output logic             ctr_rst_stb
);

    logic [WORD_W-1:0] shreg;
    logic              le_sync;
    logic              wr_en;
    tgt_e              addr;

    cfg3w_shift #(.WORD_W(WORD_W)) u_shift (
        .ser_clk (ser_clk),
        .rst_n   (rst_n),
        .din     (ser_data),
        .word_q  (shreg),
        .msb_o   (ser_out)
    );

    cfg3w_sync #(.STAGES(SYNC_STAGES)) u_le_sync (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .async_i (ser_le),
        .sync_o  (le_sync)
    );

    assign addr = tgt_e'(shreg[ADDR_W-1:0]);

    cfg3w_xfer_fsm u_fsm (
        .clk         (sys_clk),
        .rst_n       (rst_n),
        .le_sync     (le_sync),
        .addr        (addr),
        .wr_en       (wr_en),
        .load_stb    (load_stb),
        .ctr_rst_stb (ctr_rst_stb)
    );

    cfg3w_bank #(.PAY_W(PAY_W)) u_bank (
        .clk    (sys_clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (addr),
        .wdata  (shreg[WORD_W-1:ADDR_W]),
        .ref_q  (ref_word),
        .ab_q   (ab_word),
        .func_q (func_word),
        .init_q (init_word)
    );

    // R5: after an initialization write, function word mirrors it
    assert_init_mirror_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ctr_rst_stb |=> (func_word == init_word));

    // R5: counter reset only together with a load
    assert_rst_with_load_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ctr_rst_stb |-> load_stb);

    // R7: reset state
    always @(posedge sys_clk) begin
        if (!rst_n) begin
            assert_reset_clear_R7: assert (ref_word == '0 && ab_word == '0 &&
                func_word == '0 && init_word == '0 && !load_stb && !ctr_rst_stb);
        end
    end

endmodule

// File: tb/cfg3w_top_tb_top.sv
module cfg3w_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SER_HALF   = 20;
    localparam int NVEC       = 9;

    // Vector table: each word's low two bits pick the target
    localparam logic [23:0] VEC [NVEC] = '{
        24'hABCDE0, 24'h123455, 24'hFEDCBA, 24'h5A5A5B, 24'h000001,
        24'hFFFFFC, 24'h3C3C3E, 24'hC0FFEE, 24'h0F0F0F
    };

    logic sys_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le  = 1'b0;
    logic ser_out;
    logic [21:0] ref_word, ab_word, func_word, init_word;
    logic load_stb, ctr_rst_stb;

    int n_chk = 0;
    int n_fail = 0;
    int load_cnt = 0;
    int rst_cnt = 0;
    int long_cnt = 0;
    logic prev_load = 1'b0;
    logic prev_rst = 1'b0;

    logic [21:0] m_ref = '0, m_ab = '0, m_func = '0, m_init = '0;
    int exp_load = 0;
    int exp_rst = 0;

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    cfg3w_top dut_i (
        .sys_clk     (sys_clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .ser_le      (ser_le),
        .ser_out     (ser_out),
        .ref_word    (ref_word),
        .ab_word     (ab_word),
        .func_word   (func_word),
        .init_word   (init_word),
        .load_stb    (load_stb),
        .ctr_rst_stb (ctr_rst_stb)
    );

    // Strobe monitor, sampled away from the active edge
    always @(negedge sys_clk) begin
        if (load_stb) load_cnt++;
        if (ctr_rst_stb) rst_cnt++;
        if ((load_stb && prev_load) || (ctr_rst_stb && prev_rst)) long_cnt++;
        prev_load = load_stb;
        prev_rst  = ctr_rst_stb;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_data = w[i];
            #SER_HALF ser_clk = 1'b1;
            #SER_HALF ser_clk = 1'b0;
        end
    endtask

    task automatic pulse_le(input int hold);
        @(negedge sys_clk);
        ser_le = 1'b1;
        repeat (hold) @(negedge sys_clk);
        ser_le = 1'b0;
        repeat (6) @(negedge sys_clk);
    endtask

    task automatic model_write(input logic [23:0] w);
        exp_load++;
        case (w[1:0])
            2'b00: m_ref = w[23:2];
            2'b01: m_ab  = w[23:2];
            2'b10: m_func = w[23:2];
            default: begin
                m_init = w[23:2];
                m_func = w[23:2];
                exp_rst++;
            end
        endcase
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3/R4 ref"},  {10'd0, ref_word},  {10'd0, m_ref});
        chk({tag, " R3/R4 ab"},   {10'd0, ab_word},   {10'd0, m_ab});
        chk({tag, " R5 func"},    {10'd0, func_word}, {10'd0, m_func});
        chk({tag, " R3 init"},    {10'd0, init_word}, {10'd0, m_init});
        chk({tag, " R6 load count"}, load_cnt, exp_load);
        chk({tag, " R5 ctr reset count"}, rst_cnt, exp_rst);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge sys_clk);
        // R7: reset state while held
        chk("R7 ser_out in reset", ser_out, 0);
        chk("R7 load_stb in reset", load_stb, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);
        check_all("R7 after reset");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            send_bits(VEC[i], 24);
            #1;
            chk("R2 ser_out is first bit", ser_out, VEC[i][23]);
            pulse_le(3);
            model_write(VEC[i]);
            check_all("vector");
        end

        // R4: shifting without latch enable changes nothing
        send_bits(24'h7FFFFF, 24);
        repeat (4) @(negedge sys_clk);
        check_all("R4 no LE");
        chk("R2 ser_out after no-LE shift", ser_out, 0);

        // R6: long latch enable gives a single commit
        pulse_le(40);
        model_write(24'h7FFFFF);
        check_all("R6 long LE");
        chk("R6 no multi-cycle strobe", long_cnt, 0);

        // R1: over-long word keeps only the last 24 bits
        send_bits(32'hF246_8001, 28);
        #1;
        chk("R1 over-long ser_out", ser_out, 0);
        pulse_le(3);
        model_write(24'h468001);
        check_all("R1 over-long");

        // R7: asynchronous reset mid-run
        @(negedge sys_clk);
        #2 rst_n = 1'b0;
        #1;
        chk("R7 ref cleared", ref_word, 0);
        chk("R7 ab cleared", ab_word, 0);
        chk("R7 func cleared", func_word, 0);
        chk("R7 init cleared", init_word, 0);
        chk("R7 ser_out cleared", ser_out, 0);
        chk("R6 strobe width overall", long_cnt, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule